// File: doc/BRIEF.md
# Dual-Rail Early-Output Array Multiplier

This block multiplies two unsigned operands of `N` bits (default 4) and returns a `2N`-bit product. It has no clock. Every operand bit and every product bit is carried on a pair of wires, a true rail and a false rail. Each pair holds either a data value or a spacer. The block forms all `N*N` partial products with a two-input AND cell that reports spacer as soon as either of its inputs returns to spacer. It then sums them in a shift-and-add carry-save array of dual-rail full adders. The last row of that array ripples the carry to the top product bit.

The block sits between the register banks of an asynchronous pipeline stage. The neighbouring stage supplies the completion detection and the four-phase handshake. A single parameter selects the rail convention:

- **Return-to-zero:** spacer is both rails low.
- **Return-to-one:** every rail is inverted, spacer is both rails high, and every gate becomes its dual.

Each full adder is a disjoint sum of minterms. As a result, exactly one term fires per data wave, every rail moves monotonically, and every product bit is data only once every operand bit is data.

Top module: `dr_array_mul`

## Requirements
- R1: Encoding. Bit k of each operand or product vector is the pair (`*_t[k]`, `*_f[k]`). With `RTO`=0, data 1 is t=1,f=0, data 0 is t=0,f=1, and spacer is t=0,f=0. With `RTO`=1 every rail is inverted, so data 1 is t=0,f=1, data 0 is t=1,f=0, and spacer is t=1,f=1.
- R2: When every operand bit holds data, every product bit holds data and the product equals the unsigned product X*Y.
- R3: When every operand bit holds spacer, every product rail pair holds spacer.
- R4: While every operand pair is legal, no product pair is ever illegal, in any mix of data and spacer. Illegal means both rails high under `RTO`=0, or both rails low under `RTO`=1.
- R5: The partial-product cell resets early. Product bit 0 is spacer whenever X bit 0 or Y bit 0 is spacer, even while the other input still holds data.
- R6: Every product bit is data at the same time only when every operand bit is data. This holds for any operand mix, during both the set wave and the reset wave.
- R7: Operand bits may change one at a time. While moving from spacer to data, a product bit that has become data keeps its value. While moving from data to spacer, a product bit that has returned to spacer stays spacer, and a data bit does not change value.
- R8: With `RTO`=1, the same logical operands give the same logical product, spacer and completion behaviour under the inverted encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_t | input | N | True rails of multiplicand X |
| x_f | input | N | False rails of multiplicand X |
| y_t | input | N | True rails of multiplier Y |
| y_f | input | N | False rails of multiplier Y |
| p_t | output | 2N | True rails of product P |
| p_f | output | 2N | False rails of product P |

## Verification
Two behaviours can land on the same step:
- the early reset of a partial-product cell, such as product bit 0 clearing while Y bit 0 still holds data;
- the completion hold in the adder array, where the higher product bits must stay data, keep their values, or stay spacer.

The bench provokes this by setting and withdrawing operand bits one per clock in shuffled orders, for both rail conventions at once. After every step, a model computed from the per-bit operand states judges three things: monotonic movement of each product pair, legality of each pair, and whether full completion appears exactly when every operand bit is data.

// File: rtl/dr_mul_pkg.sv
package dr_mul_pkg;

  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  // logical zero as a constant data pair for the chosen convention
  function automatic rail_t rail_zero(bit rto);
    rail_t r;
    r.t = rto;
    r.f = !rto;
    return r;
  endfunction

  function automatic logic rail_spacer(rail_t r, bit rto);
    return rto ? (r.t & r.f) : !(r.t | r.f);
  endfunction

  function automatic logic rail_data(rail_t r);
    return r.t ^ r.f;
  endfunction

  function automatic logic rail_bad(rail_t r, bit rto);
    return rto ? !(r.t | r.f) : (r.t & r.f);
  endfunction

  // logical value of a data pair
  function automatic logic rail_val(rail_t r, bit rto);
    return rto ? r.f : r.t;
  endfunction

endpackage

// File: rtl/dr_and_eo.sv
module dr_and_eo
  import dr_mul_pkg::*;
#(
  parameter bit RTO = 1'b0
) (
  input  rail_t a,
  input  rail_t b,
  output rail_t z
);

  generate
    if (!RTO) begin : g_rtz
      assign z.t = a.t & b.t;
      assign z.f = (a.f & b.f) | (a.f & b.t) | (a.t & b.f);
    end else begin : g_rto
      assign z.t = a.t | b.t;
      assign z.f = (a.f | b.f) & (a.f | b.t) & (a.t | b.f);
    end
  endgenerate

  always_comb begin : chk_and
    if (!$isunknown({a, b, z})) begin
      if (rail_spacer(a, RTO) || rail_spacer(b, RTO)) begin
        AST_AND_EARLY_RESET: assert (rail_spacer(z, RTO)) else $error("and cell output not spacer"); // R5
      end
      if (rail_data(a) && rail_data(b)) begin
        AST_AND_PRODUCT: assert (rail_data(z) && rail_val(z, RTO) == (rail_val(a, RTO) & rail_val(b, RTO))) else $error("and cell value wrong"); // R2
      end
    end
  end

endmodule

// File: rtl/dr_full_add.sv
module dr_full_add
  import dr_mul_pkg::*;
#(
  parameter bit RTO = 1'b0
) (
  input  rail_t a,
  input  rail_t b,
  input  rail_t c,
  output rail_t s,
  output rail_t co
);

  localparam int NTERM = 8;
  localparam logic [NTERM-1:0] ODD_SET = 8'b1001_0110;  // minterms with odd parity
  localparam logic [NTERM-1:0] MAJ_SET = 8'b1110_1000;  // minterms with two or more ones

  logic [NTERM-1:0] term;

  // one product (or sum, in the dual) per input combination; disjoint by construction
  always_comb begin
    for (int m = 0; m < NTERM; m++) begin
      logic ra, rb, rc;
      ra = m[2] ? a.t : a.f;
      rb = m[1] ? b.t : b.f;
      rc = m[0] ? c.t : c.f;
      if (RTO) term[m] = ra | rb | rc;
      else     term[m] = ra & rb & rc;
    end
  end

  generate
    if (!RTO) begin : g_rtz
      assign s.t  = |(term & ODD_SET);
      assign s.f  = |(term & ~ODD_SET);
      assign co.t = |(term & MAJ_SET);
      assign co.f = |(term & ~MAJ_SET);
    end else begin : g_rto
      assign s.t  = &(term | ~ODD_SET);
      assign s.f  = &(term | ODD_SET);
      assign co.t = &(term | ~MAJ_SET);
      assign co.f = &(term | MAJ_SET);
    end
  endgenerate

  logic [1:0] add_ref;
  assign add_ref = {1'b0, rail_val(a, RTO)} + {1'b0, rail_val(b, RTO)} + {1'b0, rail_val(c, RTO)};

  always_comb begin : chk_fa
    if (!$isunknown({a, b, c, s, co})) begin
      if (!rail_bad(a, RTO) && !rail_bad(b, RTO) && !rail_bad(c, RTO)) begin
        AST_FA_LEGAL: assert (!rail_bad(s, RTO) && !rail_bad(co, RTO)) else $error("adder output illegal"); // R4
      end
      if (rail_spacer(a, RTO) || rail_spacer(b, RTO) || rail_spacer(c, RTO)) begin
        AST_FA_INDICATE: assert (rail_spacer(s, RTO) && rail_spacer(co, RTO)) else $error("adder fired early"); // R6
      end
      if (rail_data(a) && rail_data(b) && rail_data(c)) begin
        AST_FA_SUM: assert (rail_data(s) && rail_data(co) && {rail_val(co, RTO), rail_val(s, RTO)} == add_ref) else $error("adder sum wrong"); // R2
      end
    end
  end

endmodule

// File: rtl/dr_pp_gen.sv
module dr_pp_gen
  import dr_mul_pkg::*;
#(
  parameter int N   = 4,
  parameter bit RTO = 1'b0
) (
  input  rail_t [N-1:0]        x,
  input  rail_t [N-1:0]        y,
  output rail_t [N-1:0][N-1:0] pp   // pp[i][j] = Y bit i AND X bit j, weight i+j
);

  genvar i, j;
  generate
    for (i = 0; i < N; i++) begin : g_row
      for (j = 0; j < N; j++) begin : g_col
        dr_and_eo #(.RTO(RTO)) u_and (
          .a(x[j]),
          .b(y[i]),
          .z(pp[i][j])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/dr_csa_array.sv
module dr_csa_array
  import dr_mul_pkg::*;
#(
  parameter int N   = 4,
  parameter bit RTO = 1'b0
) (
  input  rail_t [N-1:0][N-1:0] pp,
  output rail_t [2*N-1:0]      p
);

  localparam int    PW     = 2 * N;
  localparam rail_t ZERO_C = rail_zero(RTO);

  rail_t [N-1:1][N-2:0] s_w;   // row sums, s_w[i][j] weight i+j
  rail_t [N-1:1][N-2:0] c_w;   // row carries, weight i+j+1
  rail_t [N-2:0]        rc_w;  // ripple carries of the final row

  assign p[0] = pp[0][0];

  genvar i, j, k;
  generate
    for (i = 1; i < N; i++) begin : g_row
      for (j = 0; j < N - 1; j++) begin : g_col
        rail_t fa_a, fa_c;
        if (i == 1) begin : g_first
          assign fa_a = pp[0][j+1];
          assign fa_c = ZERO_C;
        end else begin : g_next
          if (j < N - 2) begin : g_mid
            assign fa_a = s_w[i-1][j+1];
          end else begin : g_edge
            assign fa_a = pp[i-1][N-1];
          end
          assign fa_c = c_w[i-1][j];
        end
        dr_full_add #(.RTO(RTO)) u_fa (
          .a (fa_a),
          .b (pp[i][j]),
          .c (fa_c),
          .s (s_w[i][j]),
          .co(c_w[i][j])
        );
      end
      assign p[i] = s_w[i][0];
    end

    for (k = 0; k < N - 1; k++) begin : g_fin
      rail_t fin_a, fin_c;
      if (k < N - 2) begin : g_sum
        assign fin_a = s_w[N-1][k+1];
      end else begin : g_top
        assign fin_a = pp[N-1][N-1];
      end
      if (k == 0) begin : g_c0
        assign fin_c = ZERO_C;
      end else begin : g_cn
        assign fin_c = rc_w[k-1];
      end
      dr_full_add #(.RTO(RTO)) u_fa (
        .a (fin_a),
        .b (c_w[N-1][k]),
        .c (fin_c),
        .s (p[N+k]),
        .co(rc_w[k])
      );
    end
  endgenerate

  assign p[PW-1] = rc_w[N-2];

endmodule

// File: rtl/dr_array_mul.sv
module dr_array_mul
  import dr_mul_pkg::*;
#(
  parameter int N   = 4,
  parameter bit RTO = 1'b0
) (
  input  logic [N-1:0]   x_t,
  input  logic [N-1:0]   x_f,
  input  logic [N-1:0]   y_t,
  input  logic [N-1:0]   y_f,
  output logic [2*N-1:0] p_t,
  output logic [2*N-1:0] p_f
);

  localparam int PW = 2 * N;

  rail_t [N-1:0]        xr, yr;
  rail_t [N-1:0][N-1:0] pp;
  rail_t [PW-1:0]       pr;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_in
      assign xr[k].t = x_t[k];
      assign xr[k].f = x_f[k];
      assign yr[k].t = y_t[k];
      assign yr[k].f = y_f[k];
    end
    for (k = 0; k < PW; k++) begin : g_out
      assign p_t[k] = pr[k].t;
      assign p_f[k] = pr[k].f;
    end
  endgenerate

  dr_pp_gen #(.N(N), .RTO(RTO)) u_pp (
    .x (xr),
    .y (yr),
    .pp(pp)
  );

  dr_csa_array #(.N(N), .RTO(RTO)) u_csa (
    .pp(pp),
    .p (pr)
  );

  // port-level observation for the checks below
  logic           in_data, in_spacer, in_legal, out_data, out_spacer, out_legal;
  logic [N-1:0]   xv, yv;
  logic [PW-1:0]  pv, prod_ref;

  always_comb begin
    in_data = 1'b1; in_spacer = 1'b1; in_legal = 1'b1;
    out_data = 1'b1; out_spacer = 1'b1; out_legal = 1'b1;
    for (int n = 0; n < N; n++) begin
      in_data   &= rail_data(xr[n]) & rail_data(yr[n]);
      in_spacer &= rail_spacer(xr[n], RTO) & rail_spacer(yr[n], RTO);
      in_legal  &= !rail_bad(xr[n], RTO) & !rail_bad(yr[n], RTO);
      xv[n] = rail_val(xr[n], RTO);
      yv[n] = rail_val(yr[n], RTO);
    end
    for (int n = 0; n < PW; n++) begin
      out_data   &= rail_data(pr[n]);
      out_spacer &= rail_spacer(pr[n], RTO);
      out_legal  &= !rail_bad(pr[n], RTO);
      pv[n] = rail_val(pr[n], RTO);
    end
  end

  assign prod_ref = PW'(xv) * PW'(yv);

  always_comb begin : chk_top
    if (!$isunknown({x_t, x_f, y_t, y_f, p_t, p_f})) begin
      if (in_spacer) begin
        AST_PROD_SPACER: assert (out_spacer) else $error("product not spacer"); // R3
      end
      if (in_data) begin
        AST_PROD_VALUE: assert (out_data && pv == prod_ref) else $error("product value wrong"); // R2
      end
      if (out_data) begin
        AST_PROD_COMPLETE: assert (in_data) else $error("product complete before operands"); // R6
      end
      if (in_legal) begin
        AST_PROD_LEGAL: assert (out_legal) else $error("illegal product pair"); // R4
      end
    end
  end

endmodule

// File: tb/dr_array_mul_test.sv
module dr_array_mul_test;

  localparam int N          = 4;
  localparam int PW         = 2 * N;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [N-1:0]  zx_t, zx_f, zy_t, zy_f, ox_t, ox_f, oy_t, oy_f;
  logic [PW-1:0] zp_t, zp_f, op_t, op_f;

  dr_array_mul #(.N(N), .RTO(1'b0)) uut (
    .x_t(zx_t), .x_f(zx_f), .y_t(zy_t), .y_f(zy_f), .p_t(zp_t), .p_f(zp_f));
  dr_array_mul #(.N(N), .RTO(1'b1)) uut_o (
    .x_t(ox_t), .x_f(ox_f), .y_t(oy_t), .y_f(oy_f), .p_t(op_t), .p_f(op_f));

  int  xs [N];            // per-bit operand state: 0 or 1 data, 2 spacer
  int  ys [N];
  int  prev_s [2][PW];    // last sampled output state per mode
  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  // R1 encoding of the operand wires from the per-bit states
  task automatic apply();
    for (int k = 0; k < N; k++) begin
      zx_t[k] = (xs[k] == 1); zx_f[k] = (xs[k] == 0);
      zy_t[k] = (ys[k] == 1); zy_f[k] = (ys[k] == 0);
      ox_t[k] = (xs[k] != 1); ox_f[k] = (xs[k] != 0);
      oy_t[k] = (ys[k] != 1); oy_f[k] = (ys[k] != 0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    apply();
    @(negedge clk);
  endtask

  // 0/1 data, 2 spacer, 3 illegal
  function automatic int dec(logic t, logic f, bit rto);
    if (rto) begin
      if (t && f) return 2;
      if (!t && !f) return 3;
      return int'(f);
    end
    if (!t && !f) return 2;
    if (t && f) return 3;
    return int'(t);
  endfunction

  function automatic int outst(bit rto, int k);
    return rto ? dec(op_t[k], op_f[k], 1'b1) : dec(zp_t[k], zp_f[k], 1'b0);
  endfunction

  function automatic bit ins_all_data();
    for (int k = 0; k < N; k++) if (xs[k] == 2 || ys[k] == 2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic report(bit ok, string req, bit rto, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got=%0d exp=%0d", req, rto ? "rto" : "rtz", got, exp);
    end
  endtask

  // product value if all outputs hold data, else -1
  function automatic int prod_of(bit rto);
    int v = 0;
    for (int k = 0; k < PW; k++) begin
      int s = outst(rto, k);
      if (s > 1) return -1;
      v += s << k;
    end
    return v;
  endfunction

  function automatic int non_spacer(bit rto);
    int c = 0;
    for (int k = 0; k < PW; k++) if (outst(rto, k) != 2) c++;
    return c;
  endfunction

  task automatic check_value(int xv, int yv);
    report(prod_of(1'b0) == xv * yv, "R2", 1'b0, prod_of(1'b0), xv * yv);
    report(prod_of(1'b1) == xv * yv, "R8", 1'b1, prod_of(1'b1), xv * yv);
  endtask

  task automatic check_spacer();
    report(non_spacer(1'b0) == 0, "R3", 1'b0, non_spacer(1'b0), 0);
    report(non_spacer(1'b1) == 0, "R3", 1'b1, non_spacer(1'b1), 0);
  endtask

  task automatic snapshot();
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < PW; k++) prev_s[m][k] = outst(m[0], k);
  endtask

  // monotonic movement, legality and completion after one-bit change
  task automatic check_step(bit set_phase);
    for (int m = 0; m < 2; m++) begin
      int mono = 0, bad = 0, ndata = 0;
      for (int k = 0; k < PW; k++) begin
        int cur = outst(m[0], k);
        int p   = prev_s[m][k];
        if (cur == 3) bad++;
        if (cur < 2) ndata++;
        if (set_phase) begin
          if (p != 2 && cur != p) mono++;
        end else begin
          if ((p == 2 && cur != 2) || (cur != 2 && cur != p)) mono++;
        end
        prev_s[m][k] = cur;
      end
      report(mono == 0, "R7", m[0], mono, 0);
      report(bad == 0, "R4", m[0], bad, 0);
      report((ndata == PW) == ins_all_data(), "R6", m[0], int'(ndata == PW), int'(ins_all_data()));
    end
  endtask

  task automatic shuffle(ref int ord[2*N], ref int unsigned seed);
    for (int k = 0; k < 2 * N; k++) ord[k] = k;
    for (int k = 2 * N - 1; k > 0; k--) begin
      int j, t;
      seed = seed * 32'd1103515245 + 32'd12345;
      j = int'((seed >> 16) % (k + 1));
      t = ord[k]; ord[k] = ord[j]; ord[j] = t;
    end
  endtask

  task automatic run_pieces(int xv, int yv, int unsigned seed);
    int ord[2*N];
    snapshot();
    shuffle(ord, seed);
    for (int n = 0; n < 2 * N; n++) begin
      int b = ord[n];
      if (b < N) xs[b] = (xv >> b) & 1;
      else       ys[b-N] = (yv >> (b - N)) & 1;
      step();
      check_step(1'b1);
    end
    check_value(xv, yv);
    shuffle(ord, seed);
    for (int n = 0; n < 2 * N; n++) begin
      int b = ord[n];
      if (b < N) xs[b] = 2;
      else       ys[b-N] = 2;
      step();
      check_step(1'b0);
    end
    check_spacer();
  endtask

  task automatic set_all(int xv, int yv);
    for (int k = 0; k < N; k++) begin
      xs[k] = (xv >> k) & 1;
      ys[k] = (yv >> k) & 1;
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < N; k++) begin
      xs[k] = 2;
      ys[k] = 2;
    end
  endtask

  initial begin
    clear_all();
    apply();
    @(negedge clk);
    // R1: spacer rails are all low in RTZ and all high in RTO
    report(zp_t == '0 && zp_f == '0, "R1", 1'b0, int'({zp_t, zp_f}), 0);
    report(op_t == '1 && op_f == '1, "R1", 1'b1, int'({op_t, op_f}), (1 << (2 * PW)) - 1);
    check_spacer();

    // R2 R3 R8: every operand pair, each followed by spacer
    for (int xv = 0; xv < (1 << N); xv++) begin
      for (int yv = 0; yv < (1 << N); yv++) begin
        set_all(xv, yv);
        step();
        check_value(xv, yv);
        clear_all();
        step();
        check_spacer();
      end
    end

    // R5: bit 0 of the product resets early
    for (int m = 0; m < 2; m++) begin
      set_all(4'hF, 4'hF);
      step();
      if (m == 0) xs[0] = 2; else ys[0] = 2;
      step();
      report(outst(1'b0, 0) == 2, "R5", 1'b0, outst(1'b0, 0), 2);
      report(outst(1'b1, 0) == 2, "R5", 1'b1, outst(1'b1, 0), 2);
      clear_all();
      step();
    end
    xs[0] = 1;
    step();
    report(outst(1'b0, 0) == 2, "R5", 1'b0, outst(1'b0, 0), 2);
    report(outst(1'b1, 0) == 2, "R5", 1'b1, outst(1'b1, 0), 2);
    clear_all();
    step();

    // R4 R6 R7: piecewise set and reset in shuffled orders
    run_pieces(15, 15, 32'd7);
    run_pieces(9, 6, 32'd101);
    run_pieces(0, 13, 32'd55);
    run_pieces(11, 0, 32'd3);
    run_pieces(5, 10, 32'd999);
    run_pieces(14, 7, 32'd4242);
    run_pieces(1, 1, 32'd17);
    run_pieces(12, 3, 32'd31337);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule